// File: doc/BRIEF.md
# AC-link Variable-Rate Slot Scheduler

This block chooses, for every outgoing AC-link frame, which of the ten PCM output slots (slots 3 to 12) carry a fresh sample. At each frame-start strobe it takes the slot-1 word of the frame just received. In variable-rate mode it reads that word as active-low sample-request flags, one per slot. It combines the requests with a per-slot enable mask and then pops one word from each due slot's transmit FIFO. In the following cycle it presents the tag word and the sample data for the frame that follows.

When variable-rate mode is off, the request flags are ignored and every enabled slot is due in every frame. A due slot whose FIFO is empty goes out marked invalid with zero data, and that slot's sticky underrun flag is set. Serializing the frame onto the link and software access to the controls are handled elsewhere.

Top module: `aclink_slot_sched`

## Requirements
- R1: While reset is asserted and after it is released, before the first frame strobe, `tag_word`, `slot_data`, `fifo_pop` and `underrun` are all zero.
- R2: In variable-rate mode, slot 3+i (lane i, i = 0..9) is requested when bit 11-i of `rx_slot1` is low in the cycle where `frame_start` is high. Bits 19..12 and 1..0 of `rx_slot1` have no effect.
- R3: `fifo_pop` is only ever high in the cycle right after a `frame_start` cycle. `tag_word` and `slot_data` change at the clock edge that ends that cycle and then hold until the next frame.
- R4: A lane whose `slot_en` bit is low is never popped and is never marked valid, whatever the request flags say.
- R5: With `vra_en` low, every lane with `slot_en` high is due in every frame, whatever `rx_slot1` holds.
- R6: Tag bit 12-i is high exactly when lane i carries a sample. Bit 15 is high when any lane carries a sample. Bits 14, 13 and 2..0 are zero.
- R7: `slot_data[20*i +: 20]` holds the word that `fifo_data[20*i +: 20]` presented while lane i was popped. A lane that carries no sample holds zero.
- R8: A due lane whose `fifo_empty` bit is high is not popped and is sent invalid with zero data, and its `underrun` bit goes high. An `underrun` bit clears only on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | One-cycle strobe per frame; `rx_slot1` is valid in this cycle |
| rx_slot1 | input | 20 | Slot-1 word of the frame just received |
| vra_en | input | 1 | Variable-rate mode enable |
| slot_en | input | 10 | Per-lane enable mask, bit i = slot 3+i |
| fifo_empty | input | 10 | Per-lane transmit FIFO empty flag |
| fifo_data | input | 200 | Per-lane FIFO head word, lane i at bits 20*i+19..20*i |
| fifo_pop | output | 10 | Per-lane FIFO pop strobe |
| tag_word | output | 16 | Tag slot for the next output frame |
| slot_data | output | 200 | Per-lane sample for the next output frame |
| underrun | output | 10 | Sticky per-lane underrun flags |

## Verification
In a single build cycle, one lane can be popped while another lane, due in the same frame, finds its FIFO empty and records an underrun. The same tag word therefore carries a set valid bit next to a cleared one. The bench provokes this over hundreds of frames with pseudo-random masks, request words and sparse empty flags, including frames where a requested lane is disabled. For each frame it computes the pop vector, the tag, the data and the accumulated underrun flags arithmetically and compares each one in the cycle where it must appear.

// File: rtl/aclink_sched_pkg.sv
`timescale 1ns/1ps
package aclink_sched_pkg;
  localparam int LANES_DEF      = 10;
  localparam int SLOT_W_DEF     = 20;
  localparam int TAG_W_DEF      = 16;
  localparam int REQ_TOP_BIT    = 11;  // request flag of the first PCM slot
  localparam int TAG_TOP_LANE   = 12;  // tag valid bit of the first PCM slot
  localparam int FRAME_OK_BIT   = 15;

  typedef enum logic {
    SCHED_IDLE  = 1'b0,
    SCHED_BUILD = 1'b1
  } sched_phase_e;
endpackage

// File: rtl/aclink_rst_sync.sv
`timescale 1ns/1ps
module aclink_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/aclink_req_capture.sv
`timescale 1ns/1ps
module aclink_req_capture #(
  parameter int LANES   = 10,
  parameter int SLOT_W  = 20,
  parameter int REQ_TOP = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [SLOT_W-1:0] rx_word,
  output logic [LANES-1:0]  req_q
);
  logic [LANES-1:0] req_decoded;
  logic [LANES-1:0] req_d;

  // Flags are active low; lane i sits at bit REQ_TOP-i.
  for (genvar i = 0; i < LANES; i++) begin : g_decode
    assign req_decoded[i] = ~rx_word[REQ_TOP-i];
  end

  always_comb begin
    req_d = req_q;
    if (capture) req_d = req_decoded;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end
endmodule

// File: rtl/aclink_fill_lane.sv
`timescale 1ns/1ps
module aclink_fill_lane #(
  parameter int SLOT_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              build,
  input  logic              due,
  input  logic              empty,
  input  logic [SLOT_W-1:0] head_word,
  output logic              pop,
  output logic              valid_q,
  output logic [SLOT_W-1:0] data_q,
  output logic              underrun_q
);
  logic              valid_d;
  logic [SLOT_W-1:0] data_d;
  logic              underrun_d;
  logic              take;

  assign take = build & due & ~empty;
  assign pop  = take;

  always_comb begin
    valid_d    = valid_q;
    data_d     = data_q;
    underrun_d = underrun_q;
    if (build) begin
      valid_d = take;
      data_d  = take ? head_word : '0;
      if (due && empty) underrun_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      data_q     <= '0;
      underrun_q <= 1'b0;
    end else begin
      valid_q    <= valid_d;
      data_q     <= data_d;
      underrun_q <= underrun_d;
    end
  end
endmodule

// File: rtl/aclink_tag_builder.sv
`timescale 1ns/1ps
module aclink_tag_builder #(
  parameter int LANES    = 10,
  parameter int TAG_W    = 16,
  parameter int TAG_TOP  = 12,
  parameter int FRAME_OK = 15
) (
  input  logic [LANES-1:0] lane_valid,
  output logic [TAG_W-1:0] tag
);
  always_comb begin
    tag = '0;
    for (int i = 0; i < LANES; i++) begin
      tag[TAG_TOP-i] = lane_valid[i];
    end
    tag[FRAME_OK] = |lane_valid;
  end
endmodule

// File: rtl/aclink_slot_sched.sv
`timescale 1ns/1ps
module aclink_slot_sched
  import aclink_sched_pkg::*;
#(
  parameter int LANES  = LANES_DEF,
  parameter int SLOT_W = SLOT_W_DEF,
  parameter int TAG_W  = TAG_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_start,
  input  logic [SLOT_W-1:0]       rx_slot1,
  input  logic                    vra_en,
  input  logic [LANES-1:0]        slot_en,
  input  logic [LANES-1:0]        fifo_empty,
  input  logic [LANES*SLOT_W-1:0] fifo_data,
  output logic [LANES-1:0]        fifo_pop,
  output logic [TAG_W-1:0]        tag_word,
  output logic [LANES*SLOT_W-1:0] slot_data,
  output logic [LANES-1:0]        underrun
);
  localparam int DATA_W = LANES * SLOT_W;

  logic             rst_sync_n;
  sched_phase_e     phase_q;
  sched_phase_e     phase_d;
  logic             build_q;
  logic [LANES-1:0] req_q;
  logic [LANES-1:0] due;
  logic [LANES-1:0] lane_valid;

  aclink_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  aclink_req_capture #(
    .LANES   (LANES),
    .SLOT_W  (SLOT_W),
    .REQ_TOP (REQ_TOP_BIT)
  ) u_req (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .capture (frame_start),
    .rx_word (rx_slot1),
    .req_q   (req_q)
  );

  // One build cycle follows every frame strobe.
  always_comb begin
    phase_d = frame_start ? SCHED_BUILD : SCHED_IDLE;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) phase_q <= SCHED_IDLE;
    else             phase_q <= phase_d;
  end

  assign build_q = (phase_q == SCHED_BUILD);
  assign due     = slot_en & (vra_en ? req_q : {LANES{1'b1}});

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    aclink_fill_lane #(.SLOT_W(SLOT_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .build      (build_q),
      .due        (due[i]),
      .empty      (fifo_empty[i]),
      .head_word  (fifo_data[i*SLOT_W +: SLOT_W]),
      .pop        (fifo_pop[i]),
      .valid_q    (lane_valid[i]),
      .data_q     (slot_data[i*SLOT_W +: SLOT_W]),
      .underrun_q (underrun[i])
    );
  end

  aclink_tag_builder #(
    .LANES    (LANES),
    .TAG_W    (TAG_W),
    .TAG_TOP  (TAG_TOP_LANE),
    .FRAME_OK (FRAME_OK_BIT)
  ) u_tag (
    .lane_valid (lane_valid),
    .tag        (tag_word)
  );

  logic [DATA_W-1:0] unused_width_marker;
  assign unused_width_marker = '0;
endmodule

// File: rtl/aclink_slot_sched_chk.sv
`timescale 1ns/1ps
module aclink_slot_sched_chk #(
  parameter int LANES  = 10,
  parameter int TAG_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             vra_en,
  input logic [LANES-1:0] slot_en,
  input logic [LANES-1:0] fifo_empty,
  input logic [LANES-1:0] fifo_pop,
  input logic [TAG_W-1:0] tag_word,
  input logic [LANES-1:0] underrun,
  input logic [LANES-1:0] req_q,
  input logic             build_q
);
  logic [LANES-1:0] tag_lanes;
  always_comb begin
    for (int i = 0; i < LANES; i++) tag_lanes[i] = tag_word[12-i];
  end

  // R3: pops appear only right after a frame strobe
  a_r3_pop_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (|fifo_pop) |-> $past(frame_start));

  // R6: tag lane bits reflect last cycle's pops
  a_r6_tag_matches_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $past(build_q) |-> (tag_lanes == $past(fifo_pop)));

  // R4: disabled lanes are never popped
  a_r4_mask_gates_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop & ~slot_en) == '0);

  // R8: empty FIFOs are never popped
  a_r8_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop & fifo_empty) == '0);

  // R8: underrun bits are sticky
  a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun & $past(underrun)) == $past(underrun));

  // R2: in variable-rate mode only requested lanes are popped
  a_r2_pop_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    vra_en |-> ((fifo_pop & ~req_q) == '0));
endmodule

bind aclink_slot_sched aclink_slot_sched_chk #(
  .LANES (LANES),
  .TAG_W (TAG_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .vra_en      (vra_en),
  .slot_en     (slot_en),
  .fifo_empty  (fifo_empty),
  .fifo_pop    (fifo_pop),
  .tag_word    (tag_word),
  .underrun    (underrun),
  .req_q       (req_q),
  .build_q     (build_q)
);

// File: tb/aclink_slot_sched_test.sv
`timescale 1ns/1ps
module aclink_slot_sched_test;
  localparam int L = 10;
  localparam int W = 20;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           frame_start = 1'b0;
  logic [W-1:0]   rx_slot1 = '1;
  logic           vra_en = 1'b0;
  logic [L-1:0]   slot_en = '0;
  logic [L-1:0]   fifo_empty = '0;
  logic [L*W-1:0] fifo_data = '0;
  logic [L-1:0]   fifo_pop;
  logic [15:0]    tag_word;
  logic [L*W-1:0] slot_data;
  logic [L-1:0]   underrun;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0]    seed = 32'h1ACE_5EED;
  logic [L-1:0]   exp_und = '0;
  logic [15:0]    exp_tag;
  logic [L*W-1:0] exp_data;

  always #5 clk = ~clk;

  aclink_slot_sched uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rx_slot1(rx_slot1),
    .vra_en(vra_en), .slot_en(slot_en), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .fifo_pop(fifo_pop), .tag_word(tag_word),
    .slot_data(slot_data), .underrun(underrun)
  );

  task automatic check(input bit ok, input string req,
                       input logic [L*W-1:0] act, input logic [L*W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    frame_start = 1'b0;
    repeat (3) @(negedge clk);
    check(tag_word == '0 && slot_data == '0 && fifo_pop == '0 && underrun == '0,
          "R1 during reset", {tag_word, fifo_pop, underrun}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(tag_word == '0 && slot_data == '0 && fifo_pop == '0 && underrun == '0,
          "R1 after release", {tag_word, fifo_pop, underrun}, '0);
    exp_und = '0;
  endtask

  // One frame: strobe, pop cycle, result cycle, hold cycle.
  task automatic do_frame(input int fr, input logic vra, input logic [W-1:0] s1,
                          input logic [L-1:0] en, input logic [L-1:0] emp);
    logic [L-1:0] due;
    logic [L-1:0] pop;
    @(negedge clk);
    vra_en = vra; rx_slot1 = s1; slot_en = en; fifo_empty = emp;
    for (int i = 0; i < L; i++)
      fifo_data[i*W +: W] = W'((fr * 37 + i * 1001 + 5) & 32'hFFFFF);
    frame_start = 1'b1;
    for (int i = 0; i < L; i++)
      due[i] = en[i] & (vra ? ~s1[11-i] : 1'b1);
    pop = due & ~emp;
    exp_tag = '0;
    exp_data = '0;
    for (int i = 0; i < L; i++) begin
      exp_tag[12-i] = pop[i];
      if (pop[i]) exp_data[i*W +: W] = fifo_data[i*W +: W];
    end
    exp_tag[15] = |pop;
    exp_und = exp_und | (due & emp);
    check(fifo_pop == '0, "R3 no pop in strobe cycle", L*W'(fifo_pop), '0);
    @(negedge clk);
    frame_start = 1'b0;
    // R2 R4 R5: pop vector in the build cycle
    check(fifo_pop == pop, "R2/R4/R5 pop vector", L*W'(fifo_pop), L*W'(pop));
    @(negedge clk);
    // scramble inputs to show outputs hold (R3)
    fifo_data = ~fifo_data; rx_slot1 = ~rx_slot1; slot_en = ~slot_en;
    check(fifo_pop == '0, "R3 pop is one cycle", L*W'(fifo_pop), '0);
    check(tag_word == exp_tag, "R6 tag word", L*W'(tag_word), L*W'(exp_tag));
    check(slot_data == exp_data, "R7 slot data", slot_data, exp_data);
    check(underrun == exp_und, "R8 underrun flags", L*W'(underrun), L*W'(exp_und));
    @(negedge clk);
    check(tag_word == exp_tag && slot_data == exp_data, "R3 hold until next frame",
          L*W'(tag_word), L*W'(exp_tag));
  endtask

  initial begin
    do_reset();
    // R2: all requested via low flags, ignored bits held high
    do_frame(1, 1'b1, 20'hFF003, '1, '0);
    // R2: ignored bits low, flags high -> nothing requested
    do_frame(2, 1'b1, 20'h00FFC, '1, '0);
    // R5: variable rate off, flags say nothing, all enabled lanes due
    do_frame(3, 1'b0, 20'hFFFFF, 10'b1010110011, '0);
    // R4: all requested, partial mask
    do_frame(4, 1'b1, 20'h00000, 10'b0000011111, '0);
    // R8: due lanes empty beside popped lanes
    do_frame(5, 1'b1, 20'h00000, '1, 10'b0100000001);
    // R8: sticky after a clean frame
    do_frame(6, 1'b0, 20'h00000, '1, '0);
    do_reset();
    for (int f = 0; f < 400; f++) begin
      logic [31:0] a, b, c;
      seed = nxt(seed); a = seed;
      seed = nxt(seed); b = seed;
      seed = nxt(seed); c = seed;
      if (f % 60 == 59) do_reset();
      do_frame(10 + f, a[31] | a[30], W'(b), L'(c), L'(a & b & c));
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule